// File: doc/BRIEF.md
# Ternary Match Table for Prefix Route Lookup

This block is a small ternary lookup table for route selection. Every row stores a pattern word, a per-bit care mask and a result word (typically a next-hop index). A bit whose care flag is clear is a wildcard and agrees with either key value. One write port loads a complete row, including its valid flag, by index. One search port compares a key against all valid rows in the same cycle and registers four results: a hit flag, the index of the winning row, the winning row's result word, and the vector of every row that matched.

When several rows match, the row with the smallest index wins. The table itself never reorders rows. Software gets longest-prefix routing by writing longer prefixes to lower indices and leaving the host bits as wildcards, so that a default route sits last with no bits cared for.

The search result is tracked by a two-state machine, `tcam_pkg::res_state_e`. State RS_IDLE means no new result is on the outputs. State RS_SHOW means the registered result was captured at the last edge and `res_valid` is high. The transition RS_IDLE→RS_SHOW and the self-loop RS_SHOW→RS_SHOW are both taken on `srch_en`. The transition RS_SHOW→RS_IDLE and the self-loop RS_IDLE→RS_IDLE are taken when `srch_en` is low. Reset enters RS_IDLE.

Top module: `tcam_lookup`

## Requirements
- R1: After reset, every row is invalid, `res_valid` and `res_hit` are 0, and `res_idx`, `res_data` and `res_match` are all zero.
- R2: A cycle with `wr_en` high writes `wr_value`, `wr_care`, `wr_result` and `wr_valid` into row `wr_idx`. Writing a row with `wr_valid`=0 removes it from every later search.
- R3: Care bit 1 means the key bit must equal the stored bit, and care bit 0 makes that position a wildcard. Stored pattern 10XX0 in bits 4..0, with bits 7..5 cared for as 0, matches keys 0x10, 0x12, 0x14 and 0x16, and it does not match 0x11 or 0x18.
- R4: A row matches only when every cared-for bit equals the key bit. A single differing cared-for bit is enough to exclude the row.
- R5: When several rows match, `res_idx` and `res_data` report the matching row with the lowest index.
- R6: Bit i of `res_match` is 1 exactly when row i is valid and matches the key.
- R7: A row whose valid flag is 0 never matches, whatever its pattern and mask.
- R8: The results of a search started by `srch_en` at edge N appear after edge N, and `res_valid` is high for that one cycle. Without a new search, `res_valid` falls and the other result outputs hold their values.
- R9: When no row matches, `res_hit` is 0 and `res_idx`, `res_data` and `res_match` are 0.
- R10: When a write and a search fall in the same cycle, the search sees the old contents of the table. A search started in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one row |
| wr_idx | input | IDX_W | Index of the row to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_value | input | KEY_W | Pattern bits to store |
| wr_care | input | KEY_W | Care mask (1 = compare this bit) |
| wr_result | input | RES_W | Result word to store |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Key to search for |
| res_valid | output | 1 | High for one cycle after a search |
| res_hit | output | 1 | At least one row matched |
| res_idx | output | IDX_W | Lowest matching row index, or 0 on a miss |
| res_data | output | RES_W | Result word of that row, or 0 on a miss |
| res_match | output | ENTRIES | Match flag for each row |

## Verification
Every search result is due exactly one edge after the edge that samples `srch_en`. The bench raises the strobe at a falling edge, waits for the next rising edge, and reads all five result outputs at the falling edge that follows, when `res_valid` must be high. Writes are applied the same way. A write therefore takes effect at one rising edge, and any search that reads it is strobed on a later edge. The exception is the same-cycle case, which deliberately shares that edge. Hold behaviour is checked one further cycle later, when `res_valid` must have fallen while the other outputs stay unchanged.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    // Result-presentation states of the lookup block
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_SHOW = 1'b1
    } res_state_e;

endpackage

// File: rtl/tcam_row.sv
// One table row: storage plus its ternary compare against the search key.
module tcam_row #(
    parameter int KEY_W = 8,
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_care,
    input  logic [RES_W-1:0] wr_result,
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [RES_W-1:0] result
);

    logic             valid_q;
    logic [KEY_W-1:0] value_q;
    logic [KEY_W-1:0] care_q;
    logic [RES_W-1:0] result_q;
    logic [KEY_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            value_q  <= '0;
            care_q   <= '0;
            result_q <= '0;
        end else if (sel_wr) begin
            valid_q  <= wr_valid;
            value_q  <= wr_value;
            care_q   <= wr_care;
            result_q <= wr_result;
        end
    end

    // A differing bit only counts where the mask cares about it
    always_comb begin
        diff = (key ^ value_q) & care_q;
        hit  = valid_q && (diff == '0);
    end

    assign result = result_q;

endmodule

// File: rtl/tcam_first_hit.sv
// Picks the lowest-indexed set bit of the match vector.
module tcam_first_hit #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8,
    parameter int RES_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_care,
    input  logic [RES_W-1:0]   wr_result,
    input  logic               srch_en,
    input  logic [KEY_W-1:0]   srch_key,
    output logic               res_valid,
    output logic               res_hit,
    output logic [IDX_W-1:0]   res_idx,
    output logic [RES_W-1:0]   res_data,
    output logic [ENTRIES-1:0] res_match
);
    import tcam_pkg::*;

    logic [ENTRIES-1:0] row_hit;
    logic [RES_W-1:0]   row_result [ENTRIES];
    logic               any_hit;
    logic [IDX_W-1:0]   first_idx;
    logic [RES_W-1:0]   sel_data;

    res_state_e state_q, state_d;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_row
            tcam_row #(
                .KEY_W (KEY_W),
                .RES_W (RES_W)
            ) u_row (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel_wr    (wr_en && (wr_idx == IDX_W'(i))),
                .wr_valid  (wr_valid),
                .wr_value  (wr_value),
                .wr_care   (wr_care),
                .wr_result (wr_result),
                .key       (srch_key),
                .hit       (row_hit[i]),
                .result    (row_result[i])
            );
        end
    endgenerate

    tcam_first_hit #(
        .ENTRIES (ENTRIES)
    ) u_first (
        .match (row_hit),
        .any   (any_hit),
        .idx   (first_idx)
    );

    assign sel_data = any_hit ? row_result[first_idx] : '0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = srch_en ? RS_SHOW : RS_IDLE;
            RS_SHOW: state_d = srch_en ? RS_SHOW : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, captured when a search is strobed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_data  <= '0;
            res_match <= '0;
        end else if (srch_en) begin
            res_hit   <= any_hit;
            res_idx   <= any_hit ? first_idx : '0;
            res_data  <= sel_data;
            res_match <= row_hit;
        end
    end

    assign res_valid = (state_q == RS_SHOW);

    // Checks
    logic [ENTRIES-1:0] below_idx;
    assign below_idx = (ENTRIES'(1) << res_idx) - ENTRIES'(1);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_valid); // R8
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> !res_valid && $stable(res_hit) && $stable(res_match)); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '0 && res_data == '0 && res_match == '0)); // R9
    AST_HIT_IN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> res_match[res_idx]); // R6
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> ((res_match & below_idx) == '0)); // R5

endmodule

// File: tb/tcam_lookup_tb_top.sv
module tcam_lookup_tb_top;

    localparam int ENTRIES = 8;
    localparam int KEY_W   = 8;
    localparam int RES_W   = 4;
    localparam int IDX_W   = 3;
    localparam int NVEC    = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [IDX_W-1:0]   wr_idx = '0;
    logic               wr_valid = 1'b0;
    logic [KEY_W-1:0]   wr_value = '0;
    logic [KEY_W-1:0]   wr_care = '0;
    logic [RES_W-1:0]   wr_result = '0;
    logic               srch_en = 1'b0;
    logic [KEY_W-1:0]   srch_key = '0;
    logic               res_valid;
    logic               res_hit;
    logic [IDX_W-1:0]   res_idx;
    logic [RES_W-1:0]   res_data;
    logic [ENTRIES-1:0] res_match;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk; // 125 MHz

    tcam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_value(wr_value), .wr_care(wr_care), .wr_result(wr_result),
        .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_data(res_data), .res_match(res_match)
    );

    // {key, hit, idx, data, match}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h0A, 1'b1, 3'd0, 4'd1, 8'h1B},
        {8'h09, 1'b1, 3'd1, 4'd2, 8'h1A},
        {8'h10, 1'b1, 3'd2, 4'd3, 8'h14},
        {8'h12, 1'b1, 3'd2, 4'd3, 8'h14},
        {8'h14, 1'b1, 3'd2, 4'd3, 8'h14},
        {8'h16, 1'b1, 3'd2, 4'd3, 8'h14},
        {8'h11, 1'b1, 3'd4, 4'd5, 8'h10},
        {8'h18, 1'b1, 3'd4, 4'd5, 8'h10},
        {8'h05, 1'b1, 3'd3, 4'd4, 8'h18},
        {8'hF0, 1'b1, 3'd4, 4'd5, 8'h10}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_row(input int idx, input logic v, input logic [7:0] val,
                             input logic [7:0] care, input logic [3:0] res);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v;
        wr_value = val; wr_care = care; wr_result = res;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobe a search; return at the falling edge after the capturing edge
    task automatic search(input logic [7:0] key);
        @(negedge clk);
        srch_en = 1'b1; srch_key = key;
        @(negedge clk);
        srch_en = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic h, input int idx,
                              input int data, input int match);
        check({tag, " valid"}, int'(res_valid), 1);
        check({tag, " hit"},   int'(res_hit), int'(h));
        check({tag, " idx"},   int'(res_idx), idx);
        check({tag, " data"},  int'(res_data), data);
        check({tag, " match"}, int'(res_match), match);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 res_hit", int'(res_hit), 0);
        check("R1 res_match", int'(res_match), 0);
        rst_n = 1'b1;
        // R1/R9: empty table misses
        search(8'h0A);
        expect_res("R1 R9 empty search", 1'b0, 0, 0, 0);

        // R2: load rows
        write_row(0, 1'b1, 8'h0A, 8'hFF, 4'd1);
        write_row(1, 1'b1, 8'h08, 8'hFC, 4'd2);
        write_row(2, 1'b1, 8'h10, 8'hF9, 4'd3); // 10XX0 in bits 4..0
        write_row(3, 1'b1, 8'h00, 8'hF0, 4'd4);
        write_row(4, 1'b1, 8'h5A, 8'h00, 4'd5); // default route
        write_row(6, 1'b0, 8'h0A, 8'hFF, 4'd7); // invalid, would match 0x0A

        // R3 R4 R5 R6 R7: vector table
        for (int v = 0; v < NVEC; v++) begin
            search(VEC[v][23:16]);
            expect_res($sformatf("R3 R4 R5 R6 R7 vec%0d", v), VEC[v][15],
                       int'(VEC[v][14:12]), int'(VEC[v][11:8]), int'(VEC[v][7:0]));
        end

        // R8: hold one cycle later
        @(negedge clk);
        check("R8 valid falls", int'(res_valid), 0);
        check("R8 hit held", int'(res_hit), 1);
        check("R8 idx held", int'(res_idx), 4);
        check("R8 match held", int'(res_match), 8'h10);

        // R2/R7/R9: invalidate the default route, then miss
        write_row(4, 1'b0, 8'h00, 8'h00, 4'd5);
        search(8'hF0);
        expect_res("R2 R7 R9 invalidated", 1'b0, 0, 0, 0);

        // R10: same-cycle write and search
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_valid = 1'b1;
        wr_value = 8'hF0; wr_care = 8'hFF; wr_result = 4'd9;
        srch_en = 1'b1; srch_key = 8'hF0;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        expect_res("R10 old contents", 1'b0, 0, 0, 0);
        search(8'hF0);
        expect_res("R10 new contents", 1'b1, 5, 9, 8'h20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule